// File: doc/BRIEF.md
# Address-Triggered Bus Snoop Logger

This block sits beside a slow processor bus and samples its address and data lines on a much faster clock, 100 MHz or more. It watches for one target register address, the joystick port register at 13-bit address 0x0280 by default. On the processor bus, the data lines carry unsettled values for roughly the first half of the bus cycle in which that address appears. The address lines move away before the data lines change. For this reason the block does not take the value when the address arrives. It keeps the most recent sample taken while the address matched and commits that sample at the first sample where the address no longer matches. The committed value is held on an output, for example to drive indicator lights.

The same address detection also starts a trace recorder. It is used to study bus timing. While armed, the first sample of a run at the target address starts capture. From that sample on, every clock stores one entry holding the 13-bit address and 8-bit data into a 512-entry memory. Capture stops when the memory is full. A rearm pulse empties the trace and waits for the next run at the target address. A read port returns any stored entry by index, one cycle after the index is presented.

Top module: `bus_snoop_logger`

## Requirements
- R1: After reset, snoop_val is 0x00, snoop_valid is 0, trace_count is 0, and trace_active and trace_full are both 0. The recorder is armed.
- R2: snoop_val changes only on the clock where a run of target-address samples ends, meaning the sample at that edge does not match after a sample that did. It then takes the data of the last matching sample. Earlier samples of the run and the data of the first non-matching sample are not used. This holds for one-sample runs too.
- R3: snoop_valid becomes 1 on the first commit and stays 1 until reset.
- R4: Only an exact 13-bit match to the target address counts. Addresses that differ in any bit, such as 0x0281, 0x1280 or 0x0080, never change snoop_val.
- R5: While armed, the first sample of a target-address run starts capture. That sample is stored as entry 0, and each later clock stores its sample as the next entry. trace_active is 1 and trace_count gives the number of stored entries.
- R6: Capture stops after 512 entries. trace_count then stays at 512, trace_full is 1, trace_active is 0, and stored entries are not overwritten.
- R7: While capturing or full, further target-address runs do not restart the trace. The snoop latch still updates as in R2.
- R8: A rearm pulse sets trace_count to 0 and returns the recorder to armed, with trace_active and trace_full both 0. Rearm takes priority over a target-address run that starts on the same clock, so that run does not trigger.
- R9: rd_idx is sampled on a clock edge. The entry at that index appears on rd_addr (address field) and rd_data (data field) after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Sampled processor address bus |
| bus_data | input | 8 | Sampled processor data bus |
| rearm | input | 1 | Clears the trace and arms the recorder |
| rd_idx | input | 9 | Trace entry index to read |
| snoop_val | output | 8 | Last committed value of the target register |
| snoop_valid | output | 1 | Set once a value has been committed |
| trace_active | output | 1 | Recorder is storing entries |
| trace_full | output | 1 | Trace memory is full |
| trace_count | output | 10 | Number of stored trace entries |
| rd_addr | output | 13 | Address field of the entry read |
| rd_data | output | 8 | Data field of the entry read |

## Verification
The snoop latch is driven with runs at the target address of three, two and one samples, each with distinct data on every sample. This separates committing the last matching sample from committing the first matching sample or the first non-matching one. Near-miss addresses differing in a low bit, a high bit and a middle bit show whether the comparator checks every bit. The trace is filled with an incrementing address and data pattern, so each read-back entry shows its own index and any off-by-one in where capture starts or stops. Runs that arrive during capture, when the trace is full, and on the same clock as rearm show whether the trigger respects state and priority.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [1:0] {
      TR_ARMED   = 2'd0,
      TR_CAPTURE = 2'd1,
      TR_FULL    = 2'd2
   } trace_state_e;
endpackage

// File: rtl/snoop_match.sv
module snoop_match #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] TARGET = 'h280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              hit,
   output logic              in_win,
   output logic              first_hit,
   output logic [DATA_W-1:0] snoop_val,
   output logic              snoop_valid
);
   logic [DATA_W-1:0] hold_q;

   assign hit       = (bus_addr == TARGET);
   assign first_hit = hit && !in_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_win      <= 1'b0;
         hold_q      <= '0;
         snoop_val   <= '0;
         snoop_valid <= 1'b0;
      end else begin
         in_win <= hit;
         if (hit)
            hold_q <= bus_data;
         if (in_win && !hit) begin
            snoop_val   <= hold_q;
            snoop_valid <= 1'b1;
         end
      end
   end

   // R2
   commit_only_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_win && !hit) |=> $stable(snoop_val));

   // R3
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |=> snoop_valid);
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
   import snoop_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rearm,
   input  logic             first_hit,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [CNT_W-1:0] count,
   output trace_state_e     state
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

   always_comb begin
      wr_en  = !rearm && ((state == TR_ARMED && first_hit) || state == TR_CAPTURE);
      wr_idx = count[IDX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         state <= TR_ARMED;
      end else if (rearm) begin
         count <= '0;
         state <= TR_ARMED;
      end else if (wr_en) begin
         count <= count + CNT_W'(1);
         state <= (count == LAST) ? TR_FULL : TR_CAPTURE;
      end
   end

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R6
   full_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TR_FULL && !rearm) |=> ($stable(count) && state == TR_FULL));

   // R8
   rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (count == '0 && state == TR_ARMED));

   // R5
   capture_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TR_CAPTURE && !rearm) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
   parameter int DEPTH   = 512,
   parameter int IDX_W   = $clog2(DEPTH),
   parameter int WIDTH   = 21,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[widx] <= wdata;
   end

   generate
      if (OUT_REG) begin : g_reg_read
         always_ff @(posedge clk)
            rdata <= mem[ridx];
      end else begin : g_comb_read
         always_comb
            rdata = mem[ridx];
      end
   endgenerate
endmodule

// File: rtl/bus_snoop_logger.sv
module bus_snoop_logger
   import snoop_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 512,
   parameter logic [ADDR_W-1:0] TARGET = 'h280,
   parameter bit READ_REG = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              rearm,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] snoop_val,
   output logic              snoop_valid,
   output logic              trace_active,
   output logic              trace_full,
   output logic [CNT_W-1:0]  trace_count,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int ENT_W = ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus_snoop_logger: widths must be positive");
      end
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("bus_snoop_logger: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic             hit, in_win, first_hit;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   trace_state_e     state;
   logic [ENT_W-1:0] rd_ent;

   snoop_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET(TARGET)) u_match (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .hit(hit), .in_win(in_win), .first_hit(first_hit),
      .snoop_val(snoop_val), .snoop_valid(snoop_valid)
   );

   trace_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rearm(rearm), .first_hit(first_hit),
      .wr_en(wr_en), .wr_idx(wr_idx), .count(trace_count), .state(state)
   );

   trace_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WIDTH(ENT_W), .OUT_REG(READ_REG)) u_mem (
      .clk(clk), .we(wr_en), .widx(wr_idx), .wdata({bus_addr, bus_data}),
      .ridx(rd_idx), .rdata(rd_ent)
   );

   assign trace_active = (state == TR_CAPTURE);
   assign trace_full   = (state == TR_FULL);
   assign rd_addr      = rd_ent[ENT_W-1:DATA_W];
   assign rd_data      = rd_ent[DATA_W-1:0];

   // R5
   trigger_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TR_ARMED && hit && !in_win && !rearm) |=> (trace_active || trace_full));

   // R1
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trace_active && trace_full));
endmodule

// File: tb/tb_bus_snoop_logger.sv
module tb_bus_snoop_logger;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [12:0] bus_addr;
   logic [7:0]  bus_data;
   logic        rearm;
   logic [8:0]  rd_idx;
   logic [7:0]  snoop_val;
   logic        snoop_valid, trace_active, trace_full;
   logic [9:0]  trace_count;
   logic [12:0] rd_addr;
   logic [7:0]  rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bus_snoop_logger dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .rearm(rearm), .rd_idx(rd_idx), .snoop_val(snoop_val),
      .snoop_valid(snoop_valid), .trace_active(trace_active),
      .trace_full(trace_full), .trace_count(trace_count),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // {addr, data, expected snoop_val after this sample}
   localparam logic [28:0] VEC [16] = '{
      {13'h0000, 8'hAA, 8'h00},
      {13'h0280, 8'h11, 8'h00},
      {13'h0280, 8'h22, 8'h00},
      {13'h0280, 8'h33, 8'h00},
      {13'h0281, 8'h44, 8'h33},
      {13'h1280, 8'h55, 8'h33},
      {13'h0080, 8'h66, 8'h33},
      {13'h0280, 8'h77, 8'h33},
      {13'h0000, 8'h88, 8'h77},
      {13'h0280, 8'h99, 8'h77},
      {13'h0280, 8'h5A, 8'h77},
      {13'h0380, 8'hC3, 8'h5A},
      {13'h0000, 8'h00, 8'h5A},
      {13'h0280, 8'hF0, 8'h5A},
      {13'h0280, 8'h0F, 8'h5A},
      {13'h0FFF, 8'hEE, 8'h0F}
   };

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic cyc(logic [12:0] a, logic [7:0] d);
      bus_addr = a;
      bus_data = d;
      @(negedge clk);
   endtask

   task automatic read_ent(logic [8:0] idx, logic [12:0] ea, logic [7:0] ed, string tag);
      rd_idx = idx;
      cyc(13'h0000, 8'h00);
      chk({tag, " addr"}, rd_addr, ea);
      chk({tag, " data"}, rd_data, ed);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; rearm = 1'b0; rd_idx = '0;
      bus_addr = '0; bus_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 snoop_val", snoop_val, 0);
      chk("R1 snoop_valid", snoop_valid, 0);
      chk("R1 count", trace_count, 0);
      chk("R1 active", trace_active, 0);
      chk("R1 full", trace_full, 0);

      // R2 R3 R4: runs of 3, 2, 1 samples plus near-miss addresses
      for (int i = 0; i < 16; i++) begin
         cyc(VEC[i][28:16], VEC[i][15:8]);
         chk($sformatf("R2/R4 step %0d snoop_val", i), snoop_val, VEC[i][7:0]);
         chk($sformatf("R3 step %0d snoop_valid", i), snoop_valid, (i >= 4) ? 1 : 0);
      end

      // R5: trigger at step 1, one entry per clock through step 15
      chk("R5 count after table", trace_count, 15);
      chk("R5 active", trace_active, 1);
      read_ent(9'd0, 13'h0280, 8'h11, "R5 entry0");
      read_ent(9'd3, 13'h0281, 8'h44, "R5 entry3");
      read_ent(9'd14, 13'h0FFF, 8'hEE, "R5 entry14");

      // R8: rearm beats a same-clock target run
      rearm = 1'b1;
      cyc(13'h0280, 8'h12);
      rearm = 1'b0;
      chk("R8 count cleared", trace_count, 0);
      chk("R8 active cleared", trace_active, 0);
      chk("R8 full cleared", trace_full, 0);
      cyc(13'h0000, 8'h00);
      chk("R8 no trigger from rearm-cycle run", trace_count, 0);

      cyc(13'h0280, 8'h3C);
      chk("R5 triggered count", trace_count, 1);
      chk("R5 triggered active", trace_active, 1);
      for (int j = 0; j < 600; j++)
         cyc(13'h1000 + 13'(j), 8'(j));
      chk("R6 count at full", trace_count, 512);
      chk("R6 full flag", trace_full, 1);
      chk("R6 active off", trace_active, 0);
      read_ent(9'd0, 13'h0280, 8'h3C, "R9 entry0");
      read_ent(9'd1, 13'h1000, 8'h00, "R9 entry1");
      read_ent(9'd255, 13'h10FE, 8'hFE, "R9 entry255");
      read_ent(9'd511, 13'h11FE, 8'hFE, "R6 entry511 not overwritten");

      // R7: run while full
      cyc(13'h0280, 8'h99);
      cyc(13'h0280, 8'h98);
      cyc(13'h0000, 8'h01);
      chk("R7 snoop while full", snoop_val, 8'h98);
      chk("R7 count held", trace_count, 512);
      read_ent(9'd0, 13'h0280, 8'h3C, "R7 entry0 kept");

      // R8: rearm then fresh trigger
      rearm = 1'b1;
      cyc(13'h0000, 8'h00);
      rearm = 1'b0;
      cyc(13'h0280, 8'hD2);
      chk("R8 retrigger count", trace_count, 1);
      read_ent(9'd0, 13'h0280, 8'hD2, "R8 new entry0");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule